// File: doc/BRIEF.md
# Capability Trap-Register Write Legalizer

This block holds the two capability-valued trap registers of a capability-extended processor: the trap-vector capability (the handler entry point) and the exception-return capability (the saved program counter). A special-register swap instruction reaches it through a request port. The request carries a register index, a write-enable and the capability to write. The capability has a tag, a sealed flag, a permission field and an address. In one operation the block returns the register's previous contents and stores a legalized form of the new value. The legalizer clears the address bits that the register's alignment rule forbids. Whenever it alters the address, or the incoming value is sealed or lacks execute permission, it also clears the stored tag. This way a stored value never carries a tag that its fields cannot honour.

Every access is gated by the access-system-registers permission of the current program-counter capability. The block also watches the ordinary integer CSR path and flags any access to the two legacy integer CSRs that these capability registers replace. A configuration input says whether compressed (2-byte) instructions are present. The alignment rule of the exception-return register depends on it.

Top module: `scr_legalizer`

## Requirements
- R1: On reset both registers hold the null capability (tag 0, unsealed, permissions 0, address 0). During reset `rd_valid`, `exc_perm` and `exc_illegal` are 0.
- R2: A request made while `pcc_asr` is 0 sets `exc_perm` one cycle later with `rd_valid` at 0, and neither register changes.
- R3: A permitted request to index 28 (trap vector) or index 31 (exception return) sets `rd_valid` one cycle later, with the register's value from before the request on the read-data outputs.
- R4: A write to the trap-vector register stores address bits [1:0] as 00. If either bit was 1 in the written value, the stored tag is 0.
- R5: With `has_compressed` at 1, a write to the exception-return register stores address bit 0 as 0 and keeps bit 1. If bit 0 was 1, the stored tag is 0.
- R6: With `has_compressed` at 0, a write to the exception-return register stores address bits [1:0] as 00. If either bit was 1, the stored tag is 0.
- R7: A written value that is sealed, or whose execute permission (permission bit 1) is 0, is stored with tag 0 in either register.
- R8: Legalization never changes the sealed flag, the permission field or address bits above bit 1. The stored tag is never 1 unless the written tag was 1.
- R9: A CSR access (`csr_valid`) to address 0x305 or 0x341 sets `exc_illegal` one cycle later. Any other CSR address leaves it at 0.
- R10: A permitted request to any index other than 28 or 31 sets `exc_illegal` one cycle later, with `rd_valid` at 0, and changes no register.
- R11: A permitted request with `req_wr` at 0 returns the current value and leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Special-register request this cycle |
| req_idx | input | 5 | Special-register index |
| req_wr | input | 1 | Request also writes the register |
| wr_tag | input | 1 | Tag of the written capability |
| wr_sealed | input | 1 | Written capability is sealed |
| wr_perms | input | 8 | Permission field, bit 1 is execute |
| wr_addr | input | 32 | Address of the written capability |
| pcc_asr | input | 1 | Program counter capability may access system registers |
| has_compressed | input | 1 | Compressed instructions are present |
| csr_valid | input | 1 | Integer CSR instruction access this cycle |
| csr_addr | input | 12 | Integer CSR address |
| rd_valid | output | 1 | Read data valid, previous register value |
| rd_tag | output | 1 | Read-data tag |
| rd_sealed | output | 1 | Read-data sealed flag |
| rd_perms | output | 8 | Read-data permissions |
| rd_addr | output | 32 | Read-data address |
| exc_perm | output | 1 | Permission exception for the request |
| exc_illegal | output | 1 | Reserved or illegal register access exception |

## Verification
All results are registered once. Read data, `rd_valid`, `exc_perm` and `exc_illegal` belong to the request presented at the previous rising edge, and a register update takes effect at that same edge. The bench drives each request on a falling edge and samples the outputs at the next falling edge, half a cycle after the edge that registered them. It then issues a read-only request, so every stored value reaches the checks only through the normal read path. The expected stored values come from a model of the alignment and tag rules that uses only arithmetic, swept over both registers, both compressed settings, all four low-address patterns and every tag, seal and execute combination.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int ADDR_W    = 32;
    localparam int PERM_W    = 8;
    localparam int EXEC_BIT  = 1;
    localparam int IDX_W     = 5;
    localparam int CSR_W     = 12;
    localparam int NUM_SCR   = 2;
    localparam int SLOT_W    = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1;
    localparam int SLOT_TVEC = 0;
    localparam int SLOT_EPC  = 1;

    localparam logic [IDX_W-1:0] TVEC_IDX = 5'd28;
    localparam logic [IDX_W-1:0] EPC_IDX  = 5'd31;

    localparam logic [CSR_W-1:0] LEGACY_TVEC_CSR = 12'h305;
    localparam logic [CSR_W-1:0] LEGACY_EPC_CSR  = 12'h341;

    typedef struct packed {
        logic              tag;
        logic              sealed;
        logic [PERM_W-1:0] perms;
        logic [ADDR_W-1:0] addr;
    } cap_t;

    typedef enum logic [0:0] {
        KIND_TVEC = 1'b0,
        KIND_EPC  = 1'b1
    } scr_kind_e;

    function automatic logic [IDX_W-1:0] slot_index(int slot);
        return (slot == SLOT_TVEC) ? TVEC_IDX : EPC_IDX;
    endfunction

    function automatic scr_kind_e slot_kind(int slot);
        return (slot == SLOT_TVEC) ? KIND_TVEC : KIND_EPC;
    endfunction

    function automatic logic is_legacy_csr(logic [CSR_W-1:0] a);
        return (a == LEGACY_TVEC_CSR) || (a == LEGACY_EPC_CSR);
    endfunction

endpackage

// File: rtl/scr_cap_legalize.sv
module scr_cap_legalize
    import scr_pkg::*;
#(
    parameter scr_kind_e KIND = KIND_TVEC
) (
    input  cap_t cap_in,
    input  logic has_c,
    output cap_t cap_out
);

    logic [1:0] low_mask;

    generate
        if (KIND == KIND_TVEC) begin : g_tvec
            // direct mode only: word aligned handler entry
            assign low_mask = 2'b11;
        end else begin : g_epc
            assign low_mask = has_c ? 2'b01 : 2'b11;
        end
    endgenerate

    logic low_bad;
    logic exec_ok;

    always_comb begin
        low_bad = |(cap_in.addr[1:0] & low_mask);
        exec_ok = cap_in.perms[EXEC_BIT] & ~cap_in.sealed;

        cap_out           = cap_in;
        cap_out.addr[1:0] = cap_in.addr[1:0] & ~low_mask;
        cap_out.tag       = cap_in.tag & ~low_bad & exec_ok;
    end

endmodule

// File: rtl/scr_access_decode.sv
module scr_access_decode
    import scr_pkg::*;
(
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_idx,
    input  logic               req_wr,
    input  logic               pcc_asr,
    input  logic               csr_valid,
    input  logic [CSR_W-1:0]   csr_addr,
    output logic               perm_fault,
    output logic               illegal,
    output logic               access_ok,
    output logic [NUM_SCR-1:0] wr_strobe,
    output logic [SLOT_W-1:0]  hit_slot
);

    logic [NUM_SCR-1:0] hit;
    logic               known;

    always_comb begin
        hit      = '0;
        hit_slot = '0;
        for (int i = 0; i < NUM_SCR; i++) begin
            if (req_idx == slot_index(i)) begin
                hit[i]   = 1'b1;
                hit_slot = SLOT_W'(i);
            end
        end
        known      = |hit;
        perm_fault = req_valid & ~pcc_asr;
        access_ok  = req_valid & pcc_asr & known;
        illegal    = (req_valid & pcc_asr & ~known)
                   | (csr_valid & is_legacy_csr(csr_addr));
        wr_strobe  = (access_ok & req_wr) ? hit : '0;
    end

endmodule

// File: rtl/scr_legalizer.sv
module scr_legalizer
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              req_wr,
    input  logic              wr_tag,
    input  logic              wr_sealed,
    input  logic [PERM_W-1:0] wr_perms,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              pcc_asr,
    input  logic              has_compressed,
    input  logic              csr_valid,
    input  logic [CSR_W-1:0]  csr_addr,
    output logic              rd_valid,
    output logic              rd_tag,
    output logic              rd_sealed,
    output logic [PERM_W-1:0] rd_perms,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              exc_perm,
    output logic              exc_illegal
);

    cap_t               wr_cap;
    cap_t               scr_q [NUM_SCR];
    cap_t               rd_q;
    logic               perm_fault;
    logic               illegal;
    logic               access_ok;
    logic [NUM_SCR-1:0] wr_strobe;
    logic [SLOT_W-1:0]  hit_slot;

    assign wr_cap = '{tag: wr_tag, sealed: wr_sealed, perms: wr_perms, addr: wr_addr};

    scr_access_decode u_decode (
        .req_valid  (req_valid),
        .req_idx    (req_idx),
        .req_wr     (req_wr),
        .pcc_asr    (pcc_asr),
        .csr_valid  (csr_valid),
        .csr_addr   (csr_addr),
        .perm_fault (perm_fault),
        .illegal    (illegal),
        .access_ok  (access_ok),
        .wr_strobe  (wr_strobe),
        .hit_slot   (hit_slot)
    );

    generate
        for (genvar s = 0; s < NUM_SCR; s++) begin : g_slot
            cap_t legal_cap;

            scr_cap_legalize #(.KIND(slot_kind(s))) u_legalize (
                .cap_in  (wr_cap),
                .has_c   (has_compressed),
                .cap_out (legal_cap)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    scr_q[s] <= '0;
                end else if (wr_strobe[s]) begin
                    scr_q[s] <= legal_cap;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid    <= 1'b0;
            rd_q        <= '0;
            exc_perm    <= 1'b0;
            exc_illegal <= 1'b0;
        end else begin
            rd_valid    <= access_ok;
            rd_q        <= access_ok ? scr_q[hit_slot] : '0;
            exc_perm    <= perm_fault;
            exc_illegal <= illegal;
        end
    end

    assign rd_tag    = rd_q.tag;
    assign rd_sealed = rd_q.sealed;
    assign rd_perms  = rd_q.perms;
    assign rd_addr   = rd_q.addr;

endmodule

// File: rtl/scr_legalizer_chk.sv
module scr_legalizer_chk
    import scr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic             pcc_asr,
    input logic             csr_valid,
    input logic [CSR_W-1:0] csr_addr,
    input logic             rd_valid,
    input logic             exc_perm,
    input logic             exc_illegal,
    input cap_t             tvec_q,
    input cap_t             epc_q
);

    logic known_idx;
    assign known_idx = (req_idx == TVEC_IDX) || (req_idx == EPC_IDX);

    AST_PERM_FAULT_RAISED: assert property (@(posedge clk) disable iff (rst)
        req_valid && !pcc_asr |=> exc_perm && !rd_valid); // R2

    AST_PERM_FAULT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        exc_perm |-> $stable(tvec_q) && $stable(epc_q)); // R2

    AST_READ_RETURNED: assert property (@(posedge clk) disable iff (rst)
        req_valid && pcc_asr && known_idx |=> rd_valid && !exc_perm); // R3

    AST_TVEC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        tvec_q.addr[1:0] == 2'b00); // R4

    AST_EPC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        epc_q.addr[0] == 1'b0); // R5

    AST_TVEC_TAG_EXEC: assert property (@(posedge clk) disable iff (rst)
        tvec_q.tag |-> !tvec_q.sealed && tvec_q.perms[EXEC_BIT]); // R7

    AST_EPC_TAG_EXEC: assert property (@(posedge clk) disable iff (rst)
        epc_q.tag |-> !epc_q.sealed && epc_q.perms[EXEC_BIT]); // R7

    AST_LEGACY_CSR: assert property (@(posedge clk) disable iff (rst)
        csr_valid && (csr_addr == LEGACY_TVEC_CSR || csr_addr == LEGACY_EPC_CSR)
        |=> exc_illegal); // R9

    AST_UNKNOWN_IDX: assert property (@(posedge clk) disable iff (rst)
        req_valid && pcc_asr && !known_idx |=> exc_illegal && !rd_valid); // R10

endmodule

bind scr_legalizer scr_legalizer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_idx     (req_idx),
    .pcc_asr     (pcc_asr),
    .csr_valid   (csr_valid),
    .csr_addr    (csr_addr),
    .rd_valid    (rd_valid),
    .exc_perm    (exc_perm),
    .exc_illegal (exc_illegal),
    .tvec_q      (scr_q[scr_pkg::SLOT_TVEC]),
    .epc_q       (scr_q[scr_pkg::SLOT_EPC])
);

// File: tb/test_scr_legalizer.sv
module test_scr_legalizer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [4:0]  req_idx = '0;
    logic        req_wr = 1'b0;
    logic        wr_tag = 1'b0;
    logic        wr_sealed = 1'b0;
    logic [7:0]  wr_perms = '0;
    logic [31:0] wr_addr = '0;
    logic        pcc_asr = 1'b1;
    logic        has_compressed = 1'b1;
    logic        csr_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        rd_valid, rd_tag, rd_sealed, exc_perm, exc_illegal;
    logic [7:0]  rd_perms;
    logic [31:0] rd_addr;

    int n_chk  = 0;
    int n_fail = 0;

    // model state: {tag, sealed, perms[7:0], addr[31:0]}
    logic [41:0] model [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    scr_legalizer i_scr_legalizer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
        .req_wr(req_wr), .wr_tag(wr_tag), .wr_sealed(wr_sealed),
        .wr_perms(wr_perms), .wr_addr(wr_addr), .pcc_asr(pcc_asr),
        .has_compressed(has_compressed), .csr_valid(csr_valid),
        .csr_addr(csr_addr), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .rd_sealed(rd_sealed), .rd_perms(rd_perms), .rd_addr(rd_addr),
        .exc_perm(exc_perm), .exc_illegal(exc_illegal)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // arithmetic reference of the write rules
    function automatic logic [41:0] legal_value(int slot, logic hc, logic [41:0] c);
        logic [31:0] a;
        int          modv;
        logic        bad;
        logic        t;
        a    = c[31:0];
        modv = (slot == 1 && hc) ? 2 : 4;
        bad  = (a % modv) != 0;
        a    = a - (a % modv);
        t    = c[41] && !bad && !c[40] && c[33];
        return {t, c[40], c[39:32], a};
    endfunction

    logic [41:0] s_rd;
    logic        s_valid, s_perm, s_ill;

    task automatic access(logic v, logic [4:0] idx, logic wr, logic [41:0] c,
                          logic asr, logic cv, logic [11:0] ca);
        @(negedge clk);
        req_valid = v;  req_idx = idx;  req_wr = wr;
        {wr_tag, wr_sealed, wr_perms, wr_addr} = c;
        pcc_asr = asr;  csr_valid = cv;  csr_addr = ca;
        @(negedge clk);
        s_rd    = {rd_tag, rd_sealed, rd_perms, rd_addr};
        s_valid = rd_valid;
        s_perm  = exc_perm;
        s_ill   = exc_illegal;
        req_valid = 1'b0;
        csr_valid = 1'b0;
    endtask

    function automatic logic [4:0] idx_of(int slot);
        return (slot == 0) ? 5'd28 : 5'd31;
    endfunction

    task automatic readback(string req, int slot);
        access(1'b1, idx_of(slot), 1'b0, 42'h3_FF_DEAD_BEEF, 1'b1, 1'b0, '0);
        check({req, " readback valid"}, 64'(s_valid), 64'd1);
        check({req, " readback value"}, 64'(s_rd), 64'(model[slot]));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired (R1 to R11 incomplete)");
        summary();
        $finish;
    end

    initial begin
        model[0] = '0;
        model[1] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1 rd_valid in reset", 64'(rd_valid), 64'd0);
        check("R1 exc_perm in reset", 64'(exc_perm), 64'd0);
        check("R1 exc_illegal in reset", 64'(exc_illegal), 64'd0);
        rst = 1'b0;
        readback("R1", 0);
        readback("R1", 1);

        // R3..R8, R11: sweep both registers, both configs, all low bits, tag/seal/exec
        for (int slot = 0; slot < 2; slot++) begin
            for (int hc = 0; hc < 2; hc++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    for (int m = 0; m < 8; m++) begin
                        logic [41:0] c;
                        logic [7:0]  p;
                        string       rq;
                        p = (m[1]) ? (8'hA5 | 8'h02) : (8'hA5 & 8'hFD);
                        c = {m[0], m[2], p, 32'h4000_0000 + 32'(slot * 4096 + hc * 512 + m * 16 + lo * 1 + 32)};
                        c[1:0] = lo[1:0];
                        rq = (slot == 0) ? "R4/R7/R8" : (hc == 1 ? "R5/R7/R8" : "R6/R7/R8");
                        has_compressed = hc[0];
                        access(1'b1, idx_of(slot), 1'b1, c, 1'b1, 1'b0, '0);
                        check("R3 write returns valid", 64'(s_valid), 64'd1);
                        check("R3 write returns old value", 64'(s_rd), 64'(model[slot]));
                        model[slot] = legal_value(slot, hc[0], c);
                        readback(rq, slot);
                        readback("R11", slot);
                    end
                end
            end
        end

        // set tagged values so freezes are visible
        has_compressed = 1'b1;
        access(1'b1, 5'd28, 1'b1, {1'b1, 1'b0, 8'h02, 32'h0000_1000}, 1'b1, 1'b0, '0);
        model[0] = legal_value(0, 1'b1, {1'b1, 1'b0, 8'h02, 32'h0000_1000});
        access(1'b1, 5'd31, 1'b1, {1'b1, 1'b0, 8'h03, 32'h0000_2002}, 1'b1, 1'b0, '0);
        model[1] = legal_value(1, 1'b1, {1'b1, 1'b0, 8'h03, 32'h0000_2002});
        check("R5 tag kept for bit1-only address", 64'(model[1][41]), 64'd1);
        readback("R5", 1);

        // R2: no system-register permission
        for (int slot = 0; slot < 2; slot++) begin
            access(1'b1, idx_of(slot), 1'b1, {1'b1, 1'b0, 8'hFF, 32'h0BAD_0000}, 1'b0, 1'b0, '0);
            check("R2 exc_perm", 64'(s_perm), 64'd1);
            check("R2 no read data", 64'(s_valid), 64'd0);
            readback("R2", slot);
        end

        // R10: unknown indices
        for (int i = 0; i < 32; i++) begin
            if (i != 28 && i != 31) begin
                access(1'b1, 5'(i), 1'b1, {1'b1, 1'b0, 8'hFF, 32'h0BAD_0004}, 1'b1, 1'b0, '0);
                check("R10 exc_illegal", 64'(s_ill), 64'd1);
                check("R10 no read data", 64'(s_valid), 64'd0);
            end
        end
        readback("R10", 0);
        readback("R10", 1);

        // R9: legacy CSR addresses
        for (int a = 12'h300; a < 12'h348; a++) begin
            access(1'b0, '0, 1'b0, '0, 1'b1, 1'b1, 12'(a));
            check("R9 exc_illegal", 64'(s_ill), (a == 12'h305 || a == 12'h341) ? 64'd1 : 64'd0);
            check("R9 no read data", 64'(s_valid), 64'd0);
        end

        summary();
        $finish;
    end

endmodule